// File: doc/BRIEF.md
# 24-Hour Alarm Clock Core

This block keeps the time of day as six BCD digits (hours, minutes, seconds) and holds one alarm time. Time advances by one second on each pulse of a one-second enable input. New values are typed in one digit at a time. A candidate digit steps through 0 to 9 on every clock, and the confirm key copies whatever digit is showing into an entry buffer. The entry buffer fills from the right. A commit key then writes the buffer either into the running clock or into the alarm register.

The main six-digit display shows one of three things: the running time, the entry buffer while digits are being typed, or the stored alarm. The alarm view is shown for a fixed number of clocks after the alarm key is pressed outside an entry. A buzzer enable is raised while the running time equals an alarm that has been set since reset. The keys are single-cycle pulses that are already debounced and synchronised. Segment decoding and tone generation sit outside this block.

Top module: `alarm_clock_core`

## Requirements
- R1: While reset is active, and after it is released, the display reads 00:00:00, the candidate digit is 0, `disp_mode` is 0 (time view) and `buzz_en` is 0. Reset also clears the alarm register and its armed state.
- R2: The candidate digit advances by one on every clock and goes from 9 back to 0.
- R3: A `key_yes` pulse shifts the candidate digit present at that clock edge into the least significant nibble of the entry buffer. The older digits move up one nibble. From the next cycle `disp_mode` is 2 and `disp_digits` shows the buffer.
- R4: `key_time` during an entry loads the buffer into the running time. It then clears the buffer and returns `disp_mode` to 0. `key_time` outside an entry has no effect.
- R5: `key_alarm` during an entry loads the buffer into the alarm register and arms it. It then clears the buffer and returns `disp_mode` to 0.
- R6: `key_alarm` outside an entry sets `disp_mode` to 1, and the display shows the alarm. This lasts exactly 500 clocks, after which the view returns to mode 0. A further `key_alarm` restarts the 500-clock window.
- R7: `key_yes` pressed while the alarm is on view switches to entry mode (2) on the next cycle.
- R8: Each `tick_1s` pulse adds one second. Seconds and minutes wrap from 59 to 00 with a carry, and hours wrap from 23 to 00.
- R9: Without a tick or a load, the time holds. A load and a tick in the same cycle take the loaded value, not the loaded value plus one.
- R10: `buzz_en` is 1 exactly while the alarm is armed and the running time equals it.
- R11: When keys coincide, `key_yes` wins over `key_time`, and `key_time` wins over `key_alarm`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1s | input | 1 | One-second enable, one cycle wide |
| key_yes | input | 1 | Confirm current candidate digit |
| key_time | input | 1 | Commit entry to the running time |
| key_alarm | input | 1 | Commit entry to alarm, or view the alarm |
| disp_digits | output | 24 | Six BCD digits, [23:20] hour tens down to [3:0] second ones |
| cand_digit | output | 4 | Candidate digit for the seventh display position |
| disp_mode | output | 2 | 0 time, 1 alarm, 2 entry buffer |
| buzz_en | output | 1 | Buzzer enable |

## Verification
A corrupted digit counter shows on `disp_digits` at the first negative clock edge after the tick that wrapped it. The carry vectors therefore cover every rollover boundary with a single tick each. An off-by-one in the alarm-view counter shows as `disp_mode` changing one cycle early or late, so the bench samples both cycle 499 and cycle 500 of the window. A lost armed bit, or a wrong entry shift, shows either as `buzz_en` high straight after reset or as the display holding the wrong nibble order right after the commit key.

// File: rtl/alclk_pkg.sv
package alclk_pkg;
  localparam int DIGITS = 6;
  typedef logic [3:0]          bcd_t;
  typedef logic [DIGITS*4-1:0] hms_t;
  typedef enum logic [1:0] {
    VIEW_TIME  = 2'd0,
    VIEW_ALARM = 2'd1,
    VIEW_ENTRY = 2'd2
  } view_e;
endpackage

// File: rtl/alclk_candidate.sv
module alclk_candidate #(
  parameter int RADIX = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  output alclk_pkg::bcd_t     cand_o
);
  import alclk_pkg::*;
  localparam bcd_t LAST = bcd_t'(RADIX - 1);

  bcd_t cand_q, cand_d;

  always_comb begin
    if (cand_q == LAST) cand_d = '0;
    else                cand_d = cand_q + 4'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cand_q <= '0;
    else        cand_q <= cand_d;
  end

  assign cand_o = cand_q;

  AST_CAND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_q != LAST) |=> (cand_q == $past(cand_q) + 4'd1)); // R2
  AST_CAND_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_q == LAST) |=> (cand_q == '0)); // R2
endmodule

// File: rtl/alclk_timekeeper.sv
module alclk_timekeeper #(
  parameter int HOURS_PER_DAY = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic            load_i,
  input  alclk_pkg::hms_t load_val_i,
  output alclk_pkg::hms_t time_o
);
  import alclk_pkg::*;
  localparam bcd_t       ONES_LAST = 4'd9;
  localparam bcd_t       TENS_LAST = 4'd5;
  localparam logic [7:0] HOUR_LAST = {4'((HOURS_PER_DAY - 1) / 10), 4'((HOURS_PER_DAY - 1) % 10)};

  hms_t time_q, time_d;
  logic carry;

  always_comb begin
    time_d = time_q;
    carry  = 1'b1;
    if (load_i) begin
      time_d = load_val_i;
    end else if (tick_i) begin
      for (int p = 0; p < 2; p++) begin
        if (carry) begin
          if (time_d[8*p +: 4] == ONES_LAST) begin
            time_d[8*p +: 4] = '0;
            if (time_d[8*p+4 +: 4] == TENS_LAST) begin
              time_d[8*p+4 +: 4] = '0;
            end else begin
              time_d[8*p+4 +: 4] = time_d[8*p+4 +: 4] + 4'd1;
              carry = 1'b0;
            end
          end else begin
            time_d[8*p +: 4] = time_d[8*p +: 4] + 4'd1;
            carry = 1'b0;
          end
        end
      end
      if (carry) begin
        if (time_d[23:16] == HOUR_LAST) begin
          time_d[23:16] = '0;
        end else if (time_d[19:16] == ONES_LAST) begin
          time_d[19:16] = '0;
          time_d[23:20] = time_d[23:20] + 4'd1;
        end else begin
          time_d[19:16] = time_d[19:16] + 4'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) time_q <= '0;
    else        time_q <= time_d;
  end

  assign time_o = time_q;

  AST_TIME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !tick_i) |=> $stable(time_q)); // R9
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (time_q == $past(load_val_i))); // R9
  AST_DAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !load_i && time_q == {HOUR_LAST, 16'h5959}) |=> (time_q == '0)); // R8
endmodule

// File: rtl/alclk_entry.sv
module alclk_entry #(
  parameter int SHOW_CYCLES = 500
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               key_yes_i,
  input  logic               key_time_i,
  input  logic               key_alarm_i,
  input  alclk_pkg::bcd_t    cand_i,
  output alclk_pkg::hms_t    buf_o,
  output logic               load_time_o,
  output alclk_pkg::hms_t    alarm_o,
  output logic               armed_o,
  output alclk_pkg::view_e   view_o
);
  import alclk_pkg::*;
  localparam int             CW       = $clog2(SHOW_CYCLES);
  localparam logic [CW-1:0]  CNT_LAST = CW'(SHOW_CYCLES - 1);

  hms_t          buf_q, buf_d, alm_q, alm_d;
  logic          armed_q, armed_d;
  view_e         view_q, view_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          entering;

  assign entering = (view_q == VIEW_ENTRY);

  always_comb begin
    buf_d       = buf_q;
    alm_d       = alm_q;
    armed_d     = armed_q;
    view_d      = view_q;
    cnt_d       = cnt_q;
    load_time_o = 1'b0;
    if (key_yes_i) begin
      buf_d  = {buf_q[DIGITS*4-5:0], cand_i};
      view_d = VIEW_ENTRY;
      cnt_d  = '0;
    end else if (entering && key_time_i) begin
      load_time_o = 1'b1;
      buf_d       = '0;
      view_d      = VIEW_TIME;
    end else if (entering && key_alarm_i) begin
      alm_d   = buf_q;
      armed_d = 1'b1;
      buf_d   = '0;
      view_d  = VIEW_TIME;
    end else if (key_alarm_i) begin
      view_d = VIEW_ALARM;
      cnt_d  = '0;
    end else if (view_q == VIEW_ALARM) begin
      if (cnt_q == CNT_LAST) begin
        view_d = VIEW_TIME;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q   <= '0;
      alm_q   <= '0;
      armed_q <= 1'b0;
      view_q  <= VIEW_TIME;
      cnt_q   <= '0;
    end else begin
      buf_q   <= buf_d;
      alm_q   <= alm_d;
      armed_q <= armed_d;
      view_q  <= view_d;
      cnt_q   <= cnt_d;
    end
  end

  assign buf_o   = buf_q;
  assign alarm_o = alm_q;
  assign armed_o = armed_q;
  assign view_o  = view_q;

  AST_YES_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
    key_yes_i |=> (view_q == VIEW_ENTRY)); // R7
  AST_ALARM_VIEW_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(view_q == VIEW_ALARM) |-> $past(key_alarm_i)); // R6
  AST_ARM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (entering && key_alarm_i && !key_yes_i && !key_time_i) |=> (armed_q && alm_q == $past(buf_q))); // R5
  AST_TIME_KEY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!entering && !key_yes_i) |-> !load_time_o); // R4
endmodule

// File: rtl/alarm_clock_core.sv
module alarm_clock_core #(
  parameter int SHOW_CYCLES   = 500,
  parameter int HOURS_PER_DAY = 24,
  parameter int RADIX         = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_1s,
  input  logic        key_yes,
  input  logic        key_time,
  input  logic        key_alarm,
  output logic [23:0] disp_digits,
  output logic [3:0]  cand_digit,
  output logic [1:0]  disp_mode,
  output logic        buzz_en
);
  import alclk_pkg::*;

  bcd_t  cand;
  hms_t  entry_buf, alarm_val, time_val;
  logic  load_time, armed;
  view_e view;

  alclk_candidate #(.RADIX(RADIX)) u_cand (
    .clk(clk), .rst_n(rst_n), .cand_o(cand));

  alclk_entry #(.SHOW_CYCLES(SHOW_CYCLES)) u_entry (
    .clk(clk), .rst_n(rst_n),
    .key_yes_i(key_yes), .key_time_i(key_time), .key_alarm_i(key_alarm),
    .cand_i(cand), .buf_o(entry_buf), .load_time_o(load_time),
    .alarm_o(alarm_val), .armed_o(armed), .view_o(view));

  alclk_timekeeper #(.HOURS_PER_DAY(HOURS_PER_DAY)) u_time (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_1s), .load_i(load_time),
    .load_val_i(entry_buf), .time_o(time_val));

  always_comb begin
    unique case (view)
      VIEW_ALARM: disp_digits = alarm_val;
      VIEW_ENTRY: disp_digits = entry_buf;
      default:    disp_digits = time_val;
    endcase
  end

  assign cand_digit = cand;
  assign disp_mode  = view;
  assign buzz_en    = armed && (time_val == alarm_val);
endmodule

// File: tb/alarm_clock_core_test.sv
`timescale 1ns/1ps
module alarm_clock_core_test;
  logic        clk = 1'b0;
  logic        rst_n, tick_1s, key_yes, key_time, key_alarm;
  logic [23:0] disp_digits;
  logic [3:0]  cand_digit;
  logic [1:0]  disp_mode;
  logic        buzz_en;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  alarm_clock_core uut (
    .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .key_yes(key_yes),
    .key_time(key_time), .key_alarm(key_alarm), .disp_digits(disp_digits),
    .cand_digit(cand_digit), .disp_mode(disp_mode), .buzz_en(buzz_en));

  // start time, expected time after one tick
  localparam logic [47:0] VEC [0:7] = '{
    {24'h000000, 24'h000001}, {24'h000059, 24'h000100},
    {24'h005959, 24'h010000}, {24'h095959, 24'h100000},
    {24'h235959, 24'h000000}, {24'h123409, 24'h123410},
    {24'h195959, 24'h200000}, {24'h235859, 24'h235900}};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic y, input logic t, input logic a, input logic k);
    key_yes = y; key_time = t; key_alarm = a; tick_1s = k;
    @(negedge clk);
    key_yes = 0; key_time = 0; key_alarm = 0; tick_1s = 0;
  endtask

  task automatic enter_digit(input logic [3:0] d);
    do @(negedge clk); while (cand_digit != d);
    pulse(1, 0, 0, 0);
  endtask

  task automatic enter_value(input logic [23:0] v);
    for (int i = 5; i >= 0; i--) enter_digit(v[i*4 +: 4]);
  endtask

  task automatic set_time(input logic [23:0] v);
    enter_value(v);
    pulse(0, 1, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; tick_1s = 0; key_yes = 0; key_time = 0; key_alarm = 0;
    repeat (3) @(negedge clk);
    // R1: state held in reset
    check("R1 disp", disp_digits, 24'h0);
    check("R1 cand", cand_digit, 0);
    check("R1 mode", disp_mode, 0);
    check("R1 buzz", buzz_en, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", {disp_mode, buzz_en, disp_digits}, 0);

    // R2: candidate steps and wraps
    begin
      logic [3:0] prev;
      logic ok;
      ok = 1;
      prev = cand_digit;
      for (int i = 0; i < 25; i++) begin
        @(negedge clk);
        if (cand_digit != ((prev == 9) ? 4'd0 : prev + 4'd1)) ok = 0;
        prev = cand_digit;
      end
      check("R2 candidate sequence", ok, 1);
    end

    // R3: entry shifts from the right
    enter_digit(4'd1);
    enter_digit(4'd2);
    check("R3 buffer", disp_digits, 24'h000012);
    check("R3 mode", disp_mode, 2);
    // R4: commit to time
    pulse(0, 1, 0, 0);
    check("R4 time loaded", disp_digits, 24'h000012);
    check("R4 mode", disp_mode, 0);
    enter_digit(4'd7);
    check("R4 buffer cleared", disp_digits, 24'h000007);
    pulse(0, 1, 0, 0);
    pulse(0, 1, 0, 0);
    check("R4 time key idle ignored", {disp_mode, disp_digits}, {2'd0, 24'h000007});

    // R8: carry table
    for (int i = 0; i < 8; i++) begin
      set_time(VEC[i][47:24]);
      pulse(0, 0, 0, 1);
      check("R8 tick carry", disp_digits, VEC[i][23:0]);
    end
    // R9: hold
    repeat (20) @(negedge clk);
    check("R9 hold without tick", disp_digits, 24'h235900);
    // R9: load beats tick
    enter_value(24'h102030);
    pulse(0, 1, 0, 1);
    check("R9 load over tick", disp_digits, 24'h102030);

    // R11: yes beats time in same cycle
    enter_digit(4'd3);
    do @(negedge clk); while (cand_digit != 4);
    pulse(1, 1, 0, 0);
    check("R11 yes over time", {disp_mode, disp_digits}, {2'd2, 24'h000034});
    // R11: time beats alarm
    pulse(0, 1, 1, 0);
    check("R11 time over alarm", {disp_mode, disp_digits}, {2'd0, 24'h000034});

    // R5: alarm commit
    enter_value(24'h070809);
    pulse(0, 0, 1, 0);
    check("R5 commit returns to time", {disp_mode, disp_digits}, {2'd0, 24'h000034});
    // R6: alarm view window
    pulse(0, 0, 1, 0);
    check("R6 alarm shown", {disp_mode, disp_digits}, {2'd1, 24'h070809});
    repeat (499) @(negedge clk);
    check("R6 view at cycle 499", disp_mode, 1);
    @(negedge clk);
    check("R6 view ends at 500", {disp_mode, disp_digits}, {2'd0, 24'h000034});
    pulse(0, 0, 1, 0);
    repeat (100) @(negedge clk);
    pulse(0, 0, 1, 0);
    repeat (499) @(negedge clk);
    check("R6 restart extends view", disp_mode, 1);
    @(negedge clk);
    check("R6 restarted window ends", disp_mode, 0);
    // R7: yes during alarm view
    pulse(0, 0, 1, 0);
    enter_digit(4'd5);
    check("R7 entry from alarm view", {disp_mode, disp_digits}, {2'd2, 24'h000005});
    pulse(0, 1, 0, 0);

    // R10: buzzer
    enter_value(24'h000005);
    pulse(0, 0, 1, 0);
    set_time(24'h000004);
    check("R10 no match", buzz_en, 0);
    pulse(0, 0, 0, 1);
    check("R10 match", buzz_en, 1);
    pulse(0, 0, 0, 1);
    check("R10 past match", buzz_en, 0);

    // R1: mid-run reset clears alarm and arming
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 time cleared", disp_digits, 24'h0);
    check("R10 unarmed no buzz", buzz_en, 0);
    pulse(0, 0, 1, 0);
    check("R1 alarm cleared", {disp_mode, disp_digits}, {2'd1, 24'h0});

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule